// File: doc/BRIEF.md
# 8-bit ALU with Condition Code Register

This block is the arithmetic and logic unit of a small accumulator-based controller core, paired with its condition code register. Each cycle it takes an operation code and two 8-bit operands (`a_i`, usually the accumulator or the byte being modified, and `b_i`, the second operand). It returns an 8-bit result at once, together with a flag that says whether the operation writes that result back. The flag values the operation produces reach the condition code register on the next rising clock edge, but only when the update strobe is high.

Carry-in for the add-with-carry, subtract-with-borrow and rotate operations is taken from the registered condition code register. Successive operations with the strobe held high therefore chain through the carry, as a multi-byte add or a multi-byte shift needs. Every operation has its own mask of flags it may change. Any flag outside that mask keeps its stored value. Operand fetch, addressing and instruction decode are handled by the core around this block.

Top module: `ccu_alu8`

## Requirements
- R1: The condition code output `ccr_o` holds H at bit 4, I at bit 3, N at bit 2, Z at bit 1 and C at bit 0. Bits 7 to 5 always read 1. After a synchronous reset it reads 0xE8 (I set, all other flags clear).
- R2: `ccr_o` changes only on a rising clock edge where `ccr_we_i` is 1. It then takes the flags of the operation on `op_i`. When `ccr_we_i` is 0 it holds its value whatever the operation.
- R3: ADD (op 0x00) gives a+b and ADC (op 0x01) gives a+b+C. Both set H to the carry out of bit 3, C to the carry out of bit 7, N to result bit 7 and Z when the result is zero.
- R4: SUB (op 0x02) gives a-b, SBC (op 0x03) gives a-b-C and CMP (op 0x04) gives a-b on `res_o` without writing it. C is set when b (plus C for SBC) exceeds a as unsigned numbers. N and Z follow the result, and H is left unchanged.
- R5: AND (0x05), OR (0x06), XOR (0x07), bit test (0x08, a&b, not written), pass-through load (0x09, result b), increment (0x0A), decrement (0x0B) and test (0x0C, result a, not written) update only N and Z. H, I and C keep their values.
- R6: Complement (op 0x0E) gives ~a, updates N and Z, and forces C to 1.
- R7: Clear (op 0x0F) gives 0 and sets N=0, Z=1 and C=0.
- R8: Negate (op 0x0D) gives 0-a. C is set when a is non-zero, and N and Z follow the result.
- R9: Rotate left (op 0x13) gives {a[6:0],C} with C taking a[7]. Rotate right (op 0x14) gives {C,a[7:1]} with C taking a[0]. N and Z follow the result.
- R10: Shift left (op 0x10) gives {a[6:0],0} with C taking a[7]. Arithmetic shift right (op 0x11) keeps a[7] and logical shift right (op 0x12) shifts in 0. Both move a[0] into C, and N and Z follow the result.
- R11: Set carry (0x15), clear carry (0x16), set mask (0x17) and clear mask (0x18) change only C or I respectively. Their result is 0.
- R12: Load flags (op 0x19) copies b[4:0] into H, I, N, Z and C. Bits 7 to 5 of the register stay 1 whatever b[7:5] is.
- R13: `res_we_o` is 1 for ops 0x00-0x03, 0x05-0x07, 0x09-0x0B and 0x0D-0x14, and 0 otherwise. The codes 0x1A-0x1F give result 0, no write and no flag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (accumulator or modified byte) |
| b_i | input | 8 | Second operand |
| ccr_we_i | input | 1 | Condition code update strobe |
| res_o | output | 8 | Operation result (combinational) |
| res_we_o | output | 1 | Result is to be written back |
| ccr_o | output | 8 | Registered condition code register |

## Verification
The carry consumed by ADC, SBC and the rotates comes from the same register that the current operation rewrites. Carry read and carry update therefore fall in one cycle. The bench provokes this with back-to-back ADC, SBC and rotate operations with the strobe held high, and with a long mixed sequence where the strobe is toggled pseudo-randomly. The scoreboard predicts each result from the flags its own model left after the previous operation. It judges the combinational result before the edge and the register after it, so a carry taken from the wrong cycle shows up at once.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;

    localparam int DW      = 8;
    localparam int FLAG_N  = 5;
    localparam int CCR_W   = 8;
    localparam int FILL_W  = CCR_W - FLAG_N;

    typedef enum logic [4:0] {
        OP_ADD  = 5'h00,
        OP_ADC  = 5'h01,
        OP_SUB  = 5'h02,
        OP_SBC  = 5'h03,
        OP_CMP  = 5'h04,
        OP_AND  = 5'h05,
        OP_ORA  = 5'h06,
        OP_EOR  = 5'h07,
        OP_BIT  = 5'h08,
        OP_LD   = 5'h09,
        OP_INC  = 5'h0A,
        OP_DEC  = 5'h0B,
        OP_TST  = 5'h0C,
        OP_NEG  = 5'h0D,
        OP_COM  = 5'h0E,
        OP_CLR  = 5'h0F,
        OP_ASL  = 5'h10,
        OP_ASR  = 5'h11,
        OP_LSR  = 5'h12,
        OP_ROL  = 5'h13,
        OP_ROR  = 5'h14,
        OP_SEC  = 5'h15,
        OP_CLC  = 5'h16,
        OP_SEI  = 5'h17,
        OP_CLI  = 5'h18,
        OP_LDCC = 5'h19
    } op_e;

    // Packed so that {fill, flags} lands H..C on bits 4..0
    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RST = '{h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};
    localparam flags_t MASK_NONE = '{h: 1'b0, i: 1'b0, n: 1'b0, z: 1'b0, c: 1'b0};
    localparam flags_t MASK_ALL  = '{h: 1'b1, i: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
    localparam flags_t MASK_NZ   = '{h: 1'b0, i: 1'b0, n: 1'b1, z: 1'b1, c: 1'b0};
    localparam flags_t MASK_NZC  = '{h: 1'b0, i: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};
    localparam flags_t MASK_HNZC = '{h: 1'b1, i: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1};
    localparam flags_t MASK_C    = '{h: 1'b0, i: 1'b0, n: 1'b0, z: 1'b0, c: 1'b1};
    localparam flags_t MASK_I    = '{h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};

    // Which flags an operation is allowed to change
    function automatic flags_t flag_mask(op_e op);
        case (op)
            OP_ADD, OP_ADC:                         return MASK_HNZC;
            OP_SUB, OP_SBC, OP_CMP, OP_NEG:         return MASK_NZC;
            OP_AND, OP_ORA, OP_EOR, OP_BIT,
            OP_LD,  OP_INC, OP_DEC, OP_TST:         return MASK_NZ;
            OP_COM, OP_CLR, OP_ASL, OP_ASR,
            OP_LSR, OP_ROL, OP_ROR:                 return MASK_NZC;
            OP_SEC, OP_CLC:                         return MASK_C;
            OP_SEI, OP_CLI:                         return MASK_I;
            OP_LDCC:                                return MASK_ALL;
            default:                                return MASK_NONE;
        endcase
    endfunction

    // Operations whose result goes back to a register or memory byte
    function automatic logic writes_result(op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_AND, OP_ORA, OP_EOR, OP_LD,
            OP_INC, OP_DEC, OP_NEG, OP_COM,
            OP_CLR, OP_ASL, OP_ASR, OP_LSR,
            OP_ROL, OP_ROR:                         return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    // Operations served by the adder path
    function automatic logic uses_adder(op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
            OP_INC, OP_DEC, OP_NEG:                 return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic [CCR_W-1:0] pack_ccr(flags_t f);
        return {{FILL_W{1'b1}}, f};
    endfunction

endpackage

// File: rtl/ccu_arith.sv
`timescale 1ns/1ps
module ccu_arith
    import ccu_pkg::*;
#(
    parameter int W = DW
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         half,
    output logic         cout
);

    localparam int HB = W / 2;

    logic [W-1:0]  x_op;
    logic [W-1:0]  y_op;
    logic          c_in;
    logic          is_sub;
    logic [W:0]    sum;
    logic [HB:0]   hsum;

    // Every operation on this path becomes x + y + c_in; subtraction
    // uses the inverted subtrahend and reports borrow as inverted carry.
    always_comb begin
        x_op   = a;
        y_op   = b;
        c_in   = 1'b0;
        is_sub = 1'b0;
        case (op)
            OP_ADD: begin
            end
            OP_ADC: begin
                c_in = cin;
            end
            OP_SUB, OP_CMP: begin
                y_op   = ~b;
                c_in   = 1'b1;
                is_sub = 1'b1;
            end
            OP_SBC: begin
                y_op   = ~b;
                c_in   = ~cin;
                is_sub = 1'b1;
            end
            OP_INC: begin
                y_op = '0;
                c_in = 1'b1;
            end
            OP_DEC: begin
                y_op = '1;
            end
            OP_NEG: begin
                x_op   = '0;
                y_op   = ~a;
                c_in   = 1'b1;
                is_sub = 1'b1;
            end
            default: begin
                y_op = '0;
            end
        endcase
    end

    assign sum  = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, c_in};
    assign hsum = {1'b0, x_op[HB-1:0]} + {1'b0, y_op[HB-1:0]} + {{HB{1'b0}}, c_in};

    assign res  = sum[W-1:0];
    assign half = hsum[HB];
    assign cout = is_sub ? ~sum[W] : sum[W];

endmodule

// File: rtl/ccu_logic.sv
`timescale 1ns/1ps
module ccu_logic
    import ccu_pkg::*;
#(
    parameter int W = DW
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int MSB = W - 1;

    always_comb begin
        res  = '0;
        cout = cin;
        case (op)
            OP_AND: res = a & b;
            OP_ORA: res = a | b;
            OP_EOR: res = a ^ b;
            OP_BIT: res = a & b;
            OP_LD:  res = b;
            OP_TST: res = a;
            OP_COM: begin
                res  = ~a;
                cout = 1'b1;
            end
            OP_CLR: begin
                res  = '0;
                cout = 1'b0;
            end
            OP_ASL: begin
                res  = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            OP_ASR: begin
                res  = {a[MSB], a[MSB:1]};
                cout = a[0];
            end
            OP_LSR: begin
                res  = {1'b0, a[MSB:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            OP_ROR: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
            default: begin
                res  = '0;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/ccu_flagmerge.sv
`timescale 1ns/1ps
module ccu_flagmerge
    import ccu_pkg::*;
#(
    parameter int W = DW
) (
    input  op_e               op,
    input  logic [W-1:0]      res,
    input  logic              half,
    input  logic              cout,
    input  logic [FLAG_N-1:0] load_val,
    input  flags_t            cur,
    output flags_t            nxt
);

    flags_t raw;
    flags_t msk;

    always_comb begin
        raw.h = half;
        raw.i = (op == OP_SEI);
        raw.n = res[W-1];
        raw.z = ~|res;
        raw.c = cout;
        case (op)
            OP_SEC:  raw.c = 1'b1;
            OP_CLC:  raw.c = 1'b0;
            OP_LDCC: raw   = flags_t'(load_val);
            default: begin
            end
        endcase
    end

    assign msk = flag_mask(op);
    assign nxt = flags_t'((raw & msk) | (cur & ~msk));

endmodule

// File: rtl/ccu_ccr.sv
`timescale 1ns/1ps
module ccu_ccr
    import ccu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  flags_t           nxt,
    output flags_t           cur,
    output logic [CCR_W-1:0] ccr
);

    flags_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= FLAGS_RST;
        end else if (we) begin
            q <= nxt;
        end
    end

    assign cur = q;
    assign ccr = pack_ccr(q);

endmodule

// File: rtl/ccu_alu8.sv
`timescale 1ns/1ps
module ccu_alu8
    import ccu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic             ccr_we_i,
    output logic [W-1:0]     res_o,
    output logic             res_we_o,
    output logic [CCR_W-1:0] ccr_o
);

    op_e          op;
    flags_t       cur_f;
    flags_t       nxt_f;
    logic [W-1:0] add_res;
    logic         add_h;
    logic         add_c;
    logic [W-1:0] lgc_res;
    logic         lgc_c;
    logic         sel_add;
    logic [W-1:0] res_sel;
    logic         c_sel;

    assign op = op_e'(op_i);

    ccu_arith #(.W(W)) i_arith (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .cin  (cur_f.c),
        .res  (add_res),
        .half (add_h),
        .cout (add_c)
    );

    ccu_logic #(.W(W)) i_logic (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .cin  (cur_f.c),
        .res  (lgc_res),
        .cout (lgc_c)
    );

    assign sel_add = uses_adder(op);
    assign res_sel = sel_add ? add_res : lgc_res;
    assign c_sel   = sel_add ? add_c   : lgc_c;

    ccu_flagmerge #(.W(W)) i_merge (
        .op       (op),
        .res      (res_sel),
        .half     (add_h),
        .cout     (c_sel),
        .load_val (b_i[FLAG_N-1:0]),
        .cur      (cur_f),
        .nxt      (nxt_f)
    );

    ccu_ccr i_ccr (
        .clk (clk),
        .rst (rst),
        .we  (ccr_we_i),
        .nxt (nxt_f),
        .cur (cur_f),
        .ccr (ccr_o)
    );

    assign res_o    = res_sel;
    assign res_we_o = writes_result(op);

endmodule

// File: rtl/ccu_alu8_chk.sv
`timescale 1ns/1ps
module ccu_alu8_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] op_i,
    input logic       ccr_we_i,
    input logic       res_we_o,
    input logic [7:0] ccr_o
);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (ccr_o == 8'hE8));

    assert_upper_ones_R1: assert property (@(posedge clk) disable iff (rst)
        ccr_o[7:5] == 3'b111);

    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !ccr_we_i |=> $stable(ccr_o));

    assert_half_add_only_R3: assert property (@(posedge clk) disable iff (rst)
        (ccr_we_i && op_i != 5'h00 && op_i != 5'h01 && op_i != 5'h19)
        |=> (ccr_o[4] == $past(ccr_o[4])));

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'h04) |-> !res_we_o);

    assert_logic_keeps_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (ccr_we_i && op_i >= 5'h05 && op_i <= 5'h0C)
        |=> (ccr_o[0] == $past(ccr_o[0])));

    assert_com_sets_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (ccr_we_i && op_i == 5'h0E) |=> ccr_o[0]);

    assert_clr_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (ccr_we_i && op_i == 5'h0F) |=> (ccr_o[2:0] == 3'b010));

    assert_undef_no_write_R13: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 5'h1A) |-> !res_we_o);

endmodule

bind ccu_alu8 ccu_alu8_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .ccr_we_i (ccr_we_i),
    .res_we_o (res_we_o),
    .ccr_o    (ccr_o)
);

// File: tb/test_ccu_alu8.sv
`timescale 1ns/1ps
module test_ccu_alu8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       ccr_we_i = 1'b0;
    logic [7:0] res_o;
    logic       res_we_o;
    logic [7:0] ccr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int         op;
        logic [7:0] res;
        logic       wr;
        logic [7:0] ccr;
        logic       we;
    } item_t;

    item_t      sb[$];
    logic [7:0] model_ccr;

    always #2.5 clk = ~clk;

    ccu_alu8 i_ccu_alu8 (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .ccr_we_i (ccr_we_i),
        .res_o    (res_o),
        .res_we_o (res_we_o),
        .ccr_o    (ccr_o)
    );

    function automatic string tag_of(int op);
        if (op <= 1)  return "R3";
        if (op <= 4)  return "R4";
        if (op <= 12) return "R5";
        if (op == 13) return "R8";
        if (op == 14) return "R6";
        if (op == 15) return "R7";
        if (op <= 18) return "R10";
        if (op <= 20) return "R9";
        if (op <= 24) return "R11";
        if (op == 25) return "R12";
        return "R13";
    endfunction

    // Independent reference model built from the requirements
    function automatic item_t model(int op, int a, int b, logic [7:0] cc);
        item_t it;
        int  r  = 0;
        int  ci = int'(cc[0]);
        bit  h  = cc[4], i = cc[3], n = cc[2], z = cc[1], c = cc[0];
        bit  wr = 0;
        bit  nz = 1;
        case (op)
            0:  begin r = a + b;      h = ((a % 16) + (b % 16)) > 15;      c = r > 255; wr = 1; end
            1:  begin r = a + b + ci; h = ((a % 16) + (b % 16) + ci) > 15; c = r > 255; wr = 1; end
            2:  begin c = b > a;        r = a - b;      wr = 1; end
            3:  begin c = (b + ci) > a; r = a - b - ci; wr = 1; end
            4:  begin c = b > a;        r = a - b; end
            5:  begin r = a & b; wr = 1; end
            6:  begin r = a | b; wr = 1; end
            7:  begin r = a ^ b; wr = 1; end
            8:  begin r = a & b; end
            9:  begin r = b;     wr = 1; end
            10: begin r = a + 1; wr = 1; end
            11: begin r = a - 1; wr = 1; end
            12: begin r = a; end
            13: begin r = 0 - a;   c = (a != 0); wr = 1; end
            14: begin r = 255 - a; c = 1;        wr = 1; end
            15: begin r = 0;       c = 0;        wr = 1; end
            16: begin r = a * 2;              c = a >= 128; wr = 1; end
            17: begin r = a / 2 + (a & 128);  c = a % 2;    wr = 1; end
            18: begin r = a / 2;              c = a % 2;    wr = 1; end
            19: begin r = a * 2 + ci;         c = a >= 128; wr = 1; end
            20: begin r = a / 2 + ci * 128;   c = a % 2;    wr = 1; end
            21: begin c = 1; nz = 0; end
            22: begin c = 0; nz = 0; end
            23: begin i = 1; nz = 0; end
            24: begin i = 0; nz = 0; end
            25: begin h = b[4]; i = b[3]; n = b[2]; z = b[1]; c = b[0]; nz = 0; end
            default: nz = 0;
        endcase
        r = r & 255;
        if (nz) begin
            n = r >= 128;
            z = r == 0;
        end
        it.op  = op;
        it.res = r[7:0];
        it.wr  = wr;
        it.ccr = {3'b111, h, i, n, z, c};
        it.we  = 1'b0;
        return it;
    endfunction

    task automatic drive(input int op, input int a, input int b, input bit we);
        item_t it;
        @(negedge clk);
        op_i     = op[4:0];
        a_i      = a[7:0];
        b_i      = b[7:0];
        ccr_we_i = we;
        it       = model(op, a, b, model_ccr);
        it.we    = we;
        if (!we) it.ccr = model_ccr;
        model_ccr = it.ccr;
        sb.push_back(it);
    endtask

    task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Monitor: compare the combinational result before the edge and the
    // condition code register after it
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check8(tag_of(it.op), "res_o", res_o, it.res);
                check8("R13", "res_we_o", {7'd0, res_we_o}, {7'd0, it.wr});
                @(posedge clk);
                #1;
                check8(it.we ? tag_of(it.op) : "R2", "ccr_o", ccr_o, it.ccr);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_ccr = 8'hE8;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check8("R1", "reset ccr_o", ccr_o, 8'hE8);

        // R3: half carry, full carry and zero
        drive(0, 8'h0F, 8'h01, 1);
        drive(0, 8'hFF, 8'h01, 1);
        // R3: multi-byte chain, carry read and rewritten in the same cycle
        drive(1, 8'h80, 8'h7F, 1);
        drive(1, 8'hF0, 8'h0F, 1);
        drive(1, 8'h00, 8'h00, 1);
        // R4: borrow, equal compare, SBC chain
        drive(2, 8'h10, 8'h20, 1);
        drive(3, 8'h05, 8'h04, 1);
        drive(3, 8'h00, 8'h00, 1);
        drive(4, 8'h33, 8'h33, 1);
        drive(4, 8'h01, 8'h02, 1);
        // R5: carry set first, then logic ops must keep it
        drive(21, 0, 0, 1);
        drive(5, 8'hF0, 8'h8F, 1);
        drive(6, 8'h00, 8'h00, 1);
        drive(7, 8'hAA, 8'hAA, 1);
        drive(8, 8'h80, 8'hC0, 1);
        drive(9, 8'h00, 8'h7E, 1);
        drive(10, 8'hFF, 8'h00, 1);
        drive(11, 8'h00, 8'h00, 1);
        drive(12, 8'h80, 8'h00, 1);
        // R6, R7, R8
        drive(22, 0, 0, 1);
        drive(14, 8'hFF, 8'h00, 1);
        drive(15, 8'h5A, 8'h00, 1);
        drive(13, 8'h00, 8'h00, 1);
        drive(13, 8'h80, 8'h00, 1);
        drive(13, 8'h01, 8'h00, 1);
        // R10 shifts
        drive(16, 8'h81, 8'h00, 1);
        drive(17, 8'h81, 8'h00, 1);
        drive(18, 8'h81, 8'h00, 1);
        drive(18, 8'h01, 8'h00, 1);
        // R9 rotates through carry
        drive(21, 0, 0, 1);
        drive(19, 8'h40, 8'h00, 1);
        drive(20, 8'h01, 8'h00, 1);
        drive(20, 8'h00, 8'h00, 1);
        // R11 flag ops
        drive(23, 0, 0, 1);
        drive(24, 0, 0, 1);
        drive(21, 0, 0, 1);
        drive(22, 0, 0, 1);
        // R12 load flags, upper bits ignore writes
        drive(25, 0, 8'h00, 1);
        drive(25, 0, 8'hFF, 1);
        drive(25, 0, 8'hE5, 1);
        // R2 hold without strobe
        drive(15, 8'h12, 8'h00, 0);
        drive(0, 8'hFF, 8'hFF, 0);
        // R13 undefined codes
        drive(26, 8'h12, 8'h34, 1);
        drive(31, 8'hFF, 8'hFF, 1);

        // Mixed sequence with pseudo-random strobe
        for (int k = 0; k < 600; k++) begin
            int op;
            op = int'($urandom % 32);
            drive(op, int'($urandom % 256), int'($urandom % 256), ($urandom % 4) != 0);
        end

        @(negedge clk);
        ccr_we_i = 1'b0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule